// File: doc/BRIEF.md
# Static Memory Bank Sequencer

This block sits between an internal request port and the pins of an asynchronous static memory bus with up to four banks. A request carries a bank number, an offset within that bank, a read/write flag and write data. The controller then walks a fixed sequence of phases. It drives the address, waits an address setup time, and lowers that bank's chip select. It waits a chip-select setup time, then lowers the read or write strobe for the access time. It raises the strobe, holds chip select, raises chip select, and finally holds the address. The length of each phase comes from a per-bank cycle count.

Each bank also selects a byte-wide or half-word-wide data path and an optional four-beat page read. The settings arrive as plain input vectors, one slice per bank. They are captured when a request is accepted, so changing them mid-transfer has no effect on that transfer. A one-cycle done pulse ends every transfer, and read data is valid during that pulse.

Top module: `sram_bank_seq`

## Requirements
- R1: Out of reset and whenever `busy` is low, every `mem_cs_n` bit, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is low, and `busy` and `done` are low.
- R2: During a transfer, only chip-select bit `req_bank` goes low; bit i belongs to bank i. `mem_oe_n` and `mem_we_n` are never low together, and neither is low unless a chip select is low.
- R3: The phase counts work as follows. Address setup (chip select high, transfer started) lasts `t_adr_setup` cycles. Chip-select setup (chip select low, strobe high) lasts `t_cs_setup` cycles. Chip-select hold lasts `t_cs_hold` cycles. Address hold (chip select high again, before done) lasts `t_adr_hold` cycles. A count of 0 removes that phase entirely.
- R4: For a non-page transfer, the strobe stays low for exactly `t_access` + 1 cycles.
- R5: A read to a bank whose `bank_page` bit is set takes 4 beats. The first beat lasts `t_access` + 1 strobe cycles, and each later beat lasts `t_page_acc` + 1 cycles. The address rises by one for each beat, and `mem_oe_n` stays low across all beats. Beat k is returned in `rd_data[16k+15:16k]`. A non-page read fills beat 0 only and returns zero in the other beats.
- R6: When a bank's `bank_wide` bit is 0, it is byte-wide. The external address equals the offset, a read returns `mem_dq_i[7:0]` with bits 15:8 of the beat zero, and a write drives zero on `mem_dq_o[15:8]`. When the bit is 1, the external address is the offset shifted right by one (offset bit 0 ignored), and all 16 data bits are used.
- R7: A write lowers `mem_we_n` instead of `mem_oe_n` for a single beat, even in a page bank. `mem_dq_oe` is high from the first cycle of address setup to the last cycle of address hold, and it is low throughout a read.
- R8: `done` is high for one cycle, directly after the last phase cycle. All strobes are high in that cycle. `busy` is high from the cycle after acceptance through the done cycle.
- R9: A request is accepted only when `busy` is low. A request presented while `busy` is high is dropped and never performed.
- R10: While chip select stays low, the chip-select vector does not change. Outside read-strobe cycles, the address does not change either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_adr_setup | input | NB*4 | Per-bank address setup count, bank i at [4i+3:4i] |
| t_cs_setup | input | NB*4 | Per-bank chip-select setup count before strobe |
| t_access | input | NB*5 | Per-bank access count, strobe lasts value+1 |
| t_cs_hold | input | NB*4 | Per-bank chip-select hold count after strobe |
| t_adr_hold | input | NB*4 | Per-bank address hold count after chip select |
| t_page_acc | input | NB*4 | Per-bank page beat count, beat lasts value+1 |
| bank_wide | input | NB | 1 = half-word bank, 0 = byte bank |
| bank_page | input | NB | 1 = four-beat page reads |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_bank | input | BW | Bank number |
| req_off | input | OW | Byte offset within the bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end of transfer |
| rd_data | output | 64 | Read beats, beat k at [16k+15:16k] |
| mem_addr | output | AW | External address |
| mem_cs_n | output | NB | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_i | input | 16 | Data returned by memory |

## Verification
The hardest cases combine zero-length phases with page beats. When setup or hold counts are zero, several pin edges fall in the same cycle, and the phase boundaries can only be seen by counting pin states. The stimulus runs an all-zero bank, an all-maximum page bank, and mixed banks that have a skipped setup or hold. A bench monitor counts the cycles spent in each pin state and compares those counts with the programmed values. A dropped request can only be seen afterwards, so the bench issues a write while a long read is running and then reads that address back.

// File: rtl/sram_bank_seq.sv
module sram_bank_seq #(
  parameter int NB = 4,
  parameter int OW = 16,
  parameter int AW = 16,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NB*4-1:0] t_adr_setup,
  input  logic [NB*4-1:0] t_cs_setup,
  input  logic [NB*5-1:0] t_access,
  input  logic [NB*4-1:0] t_cs_hold,
  input  logic [NB*4-1:0] t_adr_hold,
  input  logic [NB*4-1:0] t_page_acc,
  input  logic [NB-1:0]   bank_wide,
  input  logic [NB-1:0]   bank_page,
  input  logic            req_valid,
  input  logic [BW-1:0]   req_bank,
  input  logic [OW-1:0]   req_off,
  input  logic            req_write,
  input  logic [15:0]     req_wdata,
  output logic            busy,
  output logic            done,
  output logic [63:0]     rd_data,
  output logic [AW-1:0]   mem_addr,
  output logic [NB-1:0]   mem_cs_n,
  output logic            mem_oe_n,
  output logic            mem_we_n,
  output logic [15:0]     mem_dq_o,
  output logic            mem_dq_oe,
  input  logic [15:0]     mem_dq_i
);

  typedef enum logic [2:0] {S_IDLE, S_ASU, S_CSU, S_ACC, S_PAGE, S_CSH, S_AH, S_DONE} st_t;

  st_t          st, tail_st;
  logic [4:0]   cnt, tail_cnt;
  logic [1:0]   beat;
  logic [BW-1:0] bk;
  logic         wr, wide, page;
  logic [AW-1:0] base;
  logic [15:0]  wd;
  logic [63:0]  rbuf;
  logic [3:0]   tas, tcs, tch, tah, tpa;
  logic [4:0]   tac;

  logic [3:0]   n_tas, n_tcs, n_tch, n_tah, n_tpa;
  logic [4:0]   n_tac;
  logic [15:0]  rd_beat;

  function automatic logic [4:0] dm1(input logic [3:0] v);
    return {1'b0, v - 4'd1};
  endfunction

  assign n_tas = t_adr_setup[req_bank*4 +: 4];
  assign n_tcs = t_cs_setup[req_bank*4 +: 4];
  assign n_tch = t_cs_hold[req_bank*4 +: 4];
  assign n_tah = t_adr_hold[req_bank*4 +: 4];
  assign n_tpa = t_page_acc[req_bank*4 +: 4];
  assign n_tac = t_access[req_bank*5 +: 5];

  assign rd_beat = wide ? mem_dq_i : {8'h00, mem_dq_i[7:0]};

  always_comb begin
    if (tch != 4'd0) begin
      tail_st = S_CSH;  tail_cnt = dm1(tch);
    end else if (tah != 4'd0) begin
      tail_st = S_AH;   tail_cnt = dm1(tah);
    end else begin
      tail_st = S_DONE; tail_cnt = 5'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; beat <= '0; bk <= '0;
      wr <= 1'b0; wide <= 1'b0; page <= 1'b0;
      base <= '0; wd <= '0; rbuf <= '0;
      tas <= '0; tcs <= '0; tch <= '0; tah <= '0; tpa <= '0; tac <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          bk   <= req_bank;
          wr   <= req_write;
          wide <= bank_wide[req_bank];
          page <= bank_page[req_bank];
          base <= bank_wide[req_bank] ? AW'(req_off >> 1) : AW'(req_off);
          wd   <= req_wdata;
          rbuf <= '0;
          beat <= '0;
          tas <= n_tas; tcs <= n_tcs; tch <= n_tch;
          tah <= n_tah; tpa <= n_tpa; tac <= n_tac;
          if (n_tas != 4'd0) begin
            st <= S_ASU; cnt <= dm1(n_tas);
          end else if (n_tcs != 4'd0) begin
            st <= S_CSU; cnt <= dm1(n_tcs);
          end else begin
            st <= S_ACC; cnt <= n_tac;
          end
        end
        S_ASU:
          if (cnt != 5'd0) cnt <= cnt - 5'd1;
          else if (tcs != 4'd0) begin st <= S_CSU; cnt <= dm1(tcs); end
          else begin st <= S_ACC; cnt <= tac; end
        S_CSU:
          if (cnt != 5'd0) cnt <= cnt - 5'd1;
          else begin st <= S_ACC; cnt <= tac; end
        S_ACC, S_PAGE:
          if (cnt != 5'd0) cnt <= cnt - 5'd1;
          else begin
            if (!wr) rbuf[{beat, 4'b0000} +: 16] <= rd_beat;
            if (page && !wr && beat != 2'd3) begin
              st <= S_PAGE; cnt <= {1'b0, tpa}; beat <= beat + 2'd1;
            end else begin
              st <= tail_st; cnt <= tail_cnt;
            end
          end
        S_CSH:
          if (cnt != 5'd0) cnt <= cnt - 5'd1;
          else if (tah != 4'd0) begin st <= S_AH; cnt <= dm1(tah); end
          else begin st <= S_DONE; cnt <= '0; end
        S_AH:
          if (cnt != 5'd0) cnt <= cnt - 5'd1;
          else st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic cs_on, strobe;
  assign cs_on  = (st == S_CSU) || (st == S_ACC) || (st == S_PAGE) || (st == S_CSH);
  assign strobe = (st == S_ACC) || (st == S_PAGE);

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign rd_data   = rbuf;
  assign mem_addr  = base + AW'(beat);
  assign mem_cs_n  = cs_on ? ~(NB'(1) << bk) : {NB{1'b1}};
  assign mem_oe_n  = !(strobe && !wr);
  assign mem_we_n  = !(strobe && wr);
  assign mem_dq_o  = wide ? wd : {8'h00, wd[7:0]};
  assign mem_dq_oe = wr && (st != S_IDLE) && (st != S_DONE);

endmodule

module sram_bank_seq_chk #(
  parameter int NB = 4,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic [NB-1:0] mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe
);

  logic cs_any;
  assign cs_any = (~mem_cs_n != '0);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  a_r2_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r2_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> cs_any);

  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&mem_cs_n && mem_oe_n && mem_we_n));

  a_r10_cs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_any && $past(cs_any)) |-> $stable(mem_cs_n));

  a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_any && $past(cs_any) && mem_oe_n && $past(mem_oe_n)) |-> $stable(mem_addr));

endmodule

bind sram_bank_seq sram_bank_seq_chk #(.NB(NB), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_addr(mem_addr),
  .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_bank_seq.sv
`timescale 1ns/1ps
module sim_sram_bank_seq;
  localparam int NB = 4;
  localparam int OW = 16;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NB*4-1:0] t_adr_setup, t_cs_setup, t_cs_hold, t_adr_hold, t_page_acc;
  logic [NB*5-1:0] t_access;
  logic [NB-1:0]   bank_wide, bank_page;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]      req_bank = '0;
  logic [OW-1:0]   req_off = '0;
  logic [15:0]     req_wdata = '0;
  logic            busy, done, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [63:0]     rd_data;
  logic [AW-1:0]   mem_addr;
  logic [NB-1:0]   mem_cs_n;
  logic [15:0]     mem_dq_o, mem_dq_i;

  int c_tas[NB], c_tcs[NB], c_tac[NB], c_tch[NB], c_tah[NB], c_tpa[NB];
  bit c_wide[NB], c_page[NB];

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      t_adr_setup[i*4 +: 4] = 4'(c_tas[i]);
      t_cs_setup[i*4 +: 4]  = 4'(c_tcs[i]);
      t_access[i*5 +: 5]    = 5'(c_tac[i]);
      t_cs_hold[i*4 +: 4]   = 4'(c_tch[i]);
      t_adr_hold[i*4 +: 4]  = 4'(c_tah[i]);
      t_page_acc[i*4 +: 4]  = 4'(c_tpa[i]);
      bank_wide[i] = c_wide[i];
      bank_page[i] = c_page[i];
    end
  end

  sram_bank_seq #(.NB(NB), .OW(OW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .t_adr_setup(t_adr_setup), .t_cs_setup(t_cs_setup), .t_access(t_access),
    .t_cs_hold(t_cs_hold), .t_adr_hold(t_adr_hold), .t_page_acc(t_page_acc),
    .bank_wide(bank_wide), .bank_page(bank_page),
    .req_valid(req_valid), .req_bank(req_bank), .req_off(req_off),
    .req_write(req_write), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  logic [15:0] mem [NB][256];
  logic [15:0] shadow [NB][256];

  function automatic int cs_idx(input logic [NB-1:0] c);
    for (int i = 0; i < NB; i++) if (!c[i]) return i;
    return 0;
  endfunction

  assign mem_dq_i = (!mem_oe_n && !(&mem_cs_n)) ? mem[cs_idx(mem_cs_n)][mem_addr[7:0]] : 16'hDEAD;

  always @(negedge clk)
    if (!mem_we_n && !(&mem_cs_n)) mem[cs_idx(mem_cs_n)][mem_addr[7:0]] <= mem_dq_o;

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    int bank; int asu; int csu; int str; int csh; int ah;
    logic [15:0] addr; bit wr; logic [63:0] rd;
  } exp_t;
  exp_t q[$];

  task automatic issue(input int b, input int off, input bit w, input logic [15:0] wdv);
    exp_t e;
    int a;
    a = c_wide[b] ? (off >> 1) : off;
    e.bank = b; e.wr = w; e.addr = 16'(a);
    e.asu = c_tas[b]; e.csu = c_tcs[b]; e.csh = c_tch[b]; e.ah = c_tah[b];
    e.str = c_tac[b] + 1 + ((c_page[b] && !w) ? 3 * (c_tpa[b] + 1) : 0);
    e.rd = '0;
    if (w) shadow[b][a & 255] = c_wide[b] ? wdv : {8'h00, wdv[7:0]};
    else
      for (int k = 0; k < ((c_page[b]) ? 4 : 1); k++)
        e.rd[k*16 +: 16] = c_wide[b] ? shadow[b][(a + k) & 255] : {8'h00, shadow[b][(a + k) & 255][7:0]};
    q.push_back(e);
    while (busy) @(negedge clk);
    req_bank = 2'(b); req_off = OW'(off); req_write = w; req_wdata = wdv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  int m_asu, m_csu, m_str, m_csh, m_ah, m_oe, m_bad;
  bit seen_cs, seen_str, after_done;
  logic [NB-1:0] m_cs;
  logic [15:0] m_addr;

  always @(negedge clk) if (rst_n) begin
    if (after_done) chk(!done, "R8 done one cycle", 64'(done), 64'd0);
    after_done = 0;
    if (!busy) begin
      m_asu = 0; m_csu = 0; m_str = 0; m_csh = 0; m_ah = 0; m_oe = 0; m_bad = 0;
      seen_cs = 0; seen_str = 0; m_cs = '0; m_addr = '0;
    end else if (done) begin
      after_done = 1;
      if (q.size() == 0) chk(0, "R9 unexpected transfer", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(m_asu == e.asu, "R3 address setup", 64'(m_asu), 64'(e.asu));
        chk(m_csu == e.csu, "R3 cs setup", 64'(m_csu), 64'(e.csu));
        chk(m_str == e.str, e.str == 0 ? "R4" : "R4/R5 strobe length", 64'(m_str), 64'(e.str));
        chk(m_csh == e.csh, "R3 cs hold", 64'(m_csh), 64'(e.csh));
        chk(m_ah == e.ah, "R3 address hold", 64'(m_ah), 64'(e.ah));
        chk(m_cs == (NB'(1) << e.bank), "R2 chip select", 64'(m_cs), 64'(NB'(1) << e.bank));
        chk(m_addr == e.addr, "R6 first address", 64'(m_addr), 64'(e.addr));
        chk(m_bad == 0, "R7 strobe kind", 64'(m_bad), 64'd0);
        chk(m_oe == (e.wr ? e.asu + e.csu + e.str + e.csh + e.ah : 0), "R7 data enable span",
            64'(m_oe), 64'(e.wr ? e.asu + e.csu + e.str + e.csh + e.ah : 0));
        if (!e.wr) chk(rd_data == e.rd, "R5/R6 read data", rd_data, e.rd);
      end
    end else begin
      if (mem_dq_oe) m_oe++;
      if (&mem_cs_n) begin
        if (!seen_cs) m_asu++; else m_ah++;
      end else begin
        seen_cs = 1; m_cs = ~mem_cs_n;
        if (!mem_oe_n || !mem_we_n) begin
          if (!seen_str) m_addr = mem_addr;
          if ((q.size() > 0) && (q[0].wr ? !mem_oe_n : !mem_we_n)) m_bad++;
          seen_str = 1; m_str++;
        end else if (!seen_str) m_csu++;
        else m_csh++;
      end
    end
  end

  task automatic set_bank(input int b, input int as, input int cs, input int ac, input int ch,
                          input int ah, input int pa, input bit w, input bit p);
    c_tas[b] = as; c_tcs[b] = cs; c_tac[b] = ac; c_tch[b] = ch; c_tah[b] = ah; c_tpa[b] = pa;
    c_wide[b] = w; c_page[b] = p;
  endtask

  initial begin
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < 256; a++) begin
        mem[b][a] = 16'((b * 16'h1111) ^ (a * 16'h0103 + 1));
        shadow[b][a] = mem[b][a];
      end
    set_bank(0, 2, 3, 4, 1, 2, 0, 0, 0);
    set_bank(1, 0, 0, 0, 0, 0, 0, 1, 0);
    set_bank(2, 1, 0, 2, 0, 3, 1, 0, 1);
    set_bank(3, 15, 15, 31, 15, 15, 15, 1, 1);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 busy/done idle", {busy, done}, 64'd0);
    chk(&mem_cs_n, "R1 chip selects high", 64'(mem_cs_n), 64'hF);
    chk(mem_oe_n && mem_we_n, "R1 strobes high", {mem_oe_n, mem_we_n}, 64'd3);
    chk(!mem_dq_oe, "R1 data not driven", 64'(mem_dq_oe), 64'd0);

    issue(0, 5, 0, 16'h0);
    issue(1, 9, 0, 16'h0);
    issue(3, 20, 0, 16'h0);
    issue(2, 7, 1, 16'hABCD);
    issue(2, 6, 0, 16'h0);
    issue(1, 11, 1, 16'h1234);
    issue(1, 10, 0, 16'h0);
    issue(3, 40, 1, 16'h9876);
    issue(3, 40, 0, 16'h0);

    c_tac[0] = 20;
    issue(0, 1, 0, 16'h0);
    repeat (3) @(negedge clk);
    req_bank = 2'd1; req_off = 16'd8; req_write = 1'b1; req_wdata = 16'h5555; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    issue(1, 8, 0, 16'h0);

    while (busy || q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R9 all transfers seen", 64'(q.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule